// File: doc/BRIEF.md
# Compare-Driven PWM Timer

This block is a 16-bit up-counter with two compare channels. The counter advances on an internal tick taken from the system clock divided by 2, 4 or 8, or on each rising edge of an external tick input. In normal mode the counter runs freely and wraps. Each compare match raises its own compare flag, and a match on channel 1 drives the waveform pin to a chosen level.

In PWM mode both channels shape a single waveform on the pin. A channel-1 match drives the pin to level A. A channel-2 match drives it to level B and reloads the counter with FFFCh. The counter therefore spends `C2 + 5` ticks in each period. To get a period of `t` seconds at a tick rate `f`, load `C2 = t*f - 5`. The period event raises the period flag rather than a compare flag. The compare flags stay clear, so only the period flag can request an interrupt in this mode. A one-shot mode halts the counter at the channel-1 match. When PWM and one-shot are both selected, PWM takes precedence.

Software loads each compare value as two byte writes. These are single-cycle strobes that the block always accepts in the cycle they arrive, with no back-pressure. The flags are cleared by write-one-to-clear strobes.

Top module: `pwmt_timer`

## Requirements
- R1: While reset is held, `count` reads FFFCh, `wave_pin` is 0, `prd_flag`, `cmp_flag` and `irq` are 0, and both compare values are 0000h.
- R2: `tick_sel` picks the tick source: 00 = clock/4, 01 = clock/2, 10 = clock/8, 11 = rising edge of `ext_tick`, which passes through a two-flop synchroniser. The counter advances by one on each tick.
- R3: In PWM mode a channel-2 match reloads the counter with FFFCh, so one waveform period lasts `C2 + 5` ticks.
- R4: A channel-1 match drives the pin level to `lvl_a`. In PWM mode a channel-2 match drives it to `lvl_b`. With `lvl_a`=1 and `lvl_b`=0 the high time is `C2 - C1` ticks. With equal levels the pin never changes.
- R5: In PWM mode a channel-2 match sets `prd_flag`. The `prd_clr` strobe clears it. A set and a clear in the same cycle leave the flag set.
- R6: `irq` = !`irq_mask` & ((`prd_ie` & `prd_flag`) | (`cmp_ie` & |`cmp_flag`)).
- R7: In PWM mode `cmp_flag` bits are never set by hardware.
- R8: Channel `wr_ch` takes the high byte when `wr_hi`=1 and the low byte when `wr_hi`=0. Writing the high byte disables that channel's compare until its low byte is written.
- R9: With both `pwm_en` and `oneshot_en` set, the block behaves exactly as in PWM mode.
- R10: `wave_pin` carries the pin level only while `pin_en` is 1; otherwise it is 0.
- R11: In normal mode the counter wraps freely. A channel-i match sets `cmp_flag[i-1]`, and `cmp_clr` bits clear the flags.
- R12: In one-shot mode (`oneshot_en`=1, `pwm_en`=0) the counter stops at the channel-1 match value, and the pin takes `lvl_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tick | input | 1 | External tick, asynchronous |
| tick_sel | input | 2 | Tick source select |
| pwm_en | input | 1 | PWM mode |
| oneshot_en | input | 1 | One-shot mode |
| pin_en | input | 1 | Pin output enable |
| lvl_a | input | 1 | Level applied on channel-1 match |
| lvl_b | input | 1 | Level applied on channel-2 match (PWM) |
| prd_ie | input | 1 | Period-flag interrupt enable |
| cmp_ie | input | 1 | Compare-flag interrupt enable |
| irq_mask | input | 1 | Global interrupt mask |
| wr_en | input | 1 | Compare byte write strobe |
| wr_ch | input | 1 | Channel select (0 = ch1, 1 = ch2) |
| wr_hi | input | 1 | 1 = high byte, 0 = low byte |
| wr_data | input | 8 | Byte value |
| prd_clr | input | 1 | Clear strobe for period flag |
| cmp_clr | input | 2 | Clear strobes for compare flags |
| wave_pin | output | 1 | Waveform pin |
| prd_flag | output | 1 | Period flag |
| cmp_flag | output | 2 | Compare flags ch1, ch2 |
| irq | output | 1 | Interrupt request |
| count | output | 16 | Counter value |

## Verification
The period flag's hardware set and its software clear can land in the same clock cycle. The bench provokes this by holding `prd_clr` high through several PWM periods, so that every set collides with a clear. It then counts the cycles in which the flag reads 1. If the clear won, the count would be zero. The correct count is one cycle per period, and after the clear is released the flag must stick at 1. Pulse widths and periods are scored against values computed from the compare settings, and the tick-source and mode combinations are each run through the same scoreboard.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [1:0] {
    TS_DIV4 = 2'b00,
    TS_DIV2 = 2'b01,
    TS_DIV8 = 2'b10,
    TS_EXT  = 2'b11
  } tick_src_e;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
  import pwmt_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tick_sel,
  input  logic       ext_tick,
  output logic       tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] limit;
  logic             div_hit;
  logic             sync1, sync2, sync3;
  logic             ext_rise;

  always_comb begin
    unique case (tick_src_e'(tick_sel))
      TS_DIV2: limit = PRE_W'(1);
      TS_DIV8: limit = PRE_W'(7);
      default: limit = PRE_W'(3);
    endcase
  end

  assign div_hit  = (div_q >= limit);
  assign ext_rise = sync2 & ~sync3;
  assign tick     = (tick_src_e'(tick_sel) == TS_EXT) ? ext_rise : div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= ext_tick;
      sync2 <= sync1;
      sync3 <= sync2;
      if (div_hit || tick_src_e'(tick_sel) == TS_EXT) div_q <= '0;
      else                                           div_q <= div_q + 1'b1;
    end
  end

  // R2: ticks never arrive on two consecutive cycles
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pwmt_cmp_reg.sv
module pwmt_cmp_reg #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_hi,
  input  logic [W/2-1:0] wr_data,
  output logic [W-1:0]   value,
  output logic           armed
);
  localparam int HALF = W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      armed <= 1'b1;
    end else if (wr_en) begin
      if (wr_hi) begin
        value[W-1:HALF] <= wr_data;
        armed           <= 1'b0;
      end else begin
        value[HALF-1:0] <= wr_data;
        armed           <= 1'b1;
      end
    end
  end

  // R8: a high-byte write leaves the channel disabled
  a_r8_hi_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> !armed);
  // R8: a low-byte write re-enables the channel
  a_r8_lo_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> armed);
endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick,
  input  logic [1:0]       tick_sel,
  input  logic             pwm_en,
  input  logic             oneshot_en,
  input  logic             pin_en,
  input  logic             lvl_a,
  input  logic             lvl_b,
  input  logic             prd_ie,
  input  logic             cmp_ie,
  input  logic             irq_mask,
  input  logic             wr_en,
  input  logic             wr_ch,
  input  logic             wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic             prd_clr,
  input  logic [1:0]       cmp_clr,
  output logic             wave_pin,
  output logic             prd_flag,
  output logic [1:0]       cmp_flag,
  output logic             irq,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] RELOAD = ~(CNT_W'(3));
  localparam int NCH = 2;
  localparam int NFL = NCH + 1;

  logic             tick;
  logic [CNT_W-1:0] cmp_val [NCH];
  logic [NCH-1:0]   cmp_arm;
  logic [NCH-1:0]   hit;
  logic             pwm_act, shot_act;
  logic             halted;
  logic             lvl_q;
  logic [NFL-1:0]   fl_set, fl_clr, fl_q;

  pwmt_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel),
    .ext_tick(ext_tick), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwmt_cmp_reg #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en && (wr_ch == 1'(g))), .wr_hi(wr_hi), .wr_data(wr_data),
      .value(cmp_val[g]), .armed(cmp_arm[g])
    );
    assign hit[g] = tick && !halted && cmp_arm[g] && (count == cmp_val[g]);
  end

  assign pwm_act  = pwm_en;
  assign shot_act = oneshot_en && !pwm_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= RELOAD;
      halted <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      if (tick && !halted) begin
        if (pwm_act && hit[1]) count <= RELOAD;
        else if (shot_act && hit[0]) count <= count;
        else                         count <= count + 1'b1;
      end
      if (!shot_act)                halted <= 1'b0;
      else if (hit[0])              halted <= 1'b1;
      if (pwm_act && hit[1])        lvl_q  <= lvl_b;
      else if (hit[0])              lvl_q  <= lvl_a;
    end
  end

  assign fl_set[0] = pwm_act && hit[1];
  assign fl_set[1] = !pwm_act && hit[0];
  assign fl_set[2] = !pwm_act && hit[1];
  assign fl_clr    = {cmp_clr, prd_clr};

  for (genvar f = 0; f < NFL; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fl_q[f] <= 1'b0;
      else if (fl_set[f]) fl_q[f] <= 1'b1;
      else if (fl_clr[f]) fl_q[f] <= 1'b0;
    end
  end

  assign prd_flag = fl_q[0];
  assign cmp_flag = fl_q[2:1];
  assign wave_pin = pin_en && lvl_q;
  assign irq      = !irq_mask && ((prd_ie && prd_flag) || (cmp_ie && (|cmp_flag)));

  // R3: period match reloads the counter
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_en && !halted && cmp_arm[1] && count == cmp_val[1]) |=> count == RELOAD);
  // R5: a hardware set is never lost to a same-cycle clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fl_set[0] |=> prd_flag);
  // R6: enabled, unmasked period flag raises the request
  a_r6_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_flag && prd_ie && !irq_mask) |-> irq);
  // R7: compare flags stay clear in PWM mode
  a_r7_no_cmp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && cmp_flag == 2'b00) |=> cmp_flag == 2'b00);
  // R12: a halted counter holds its value
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(count));
endmodule

// File: tb/pwmt_timer_tb.sv
module pwmt_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_tick = 1'b0;
  logic [1:0] tick_sel = 2'b01;
  logic pwm_en = 0, oneshot_en = 0, pin_en = 0, lvl_a = 0, lvl_b = 0;
  logic prd_ie = 0, cmp_ie = 0, irq_mask = 0;
  logic wr_en = 0, wr_ch = 0, wr_hi = 0;
  logic [7:0] wr_data = 0;
  logic prd_clr = 0;
  logic [1:0] cmp_clr = 0;
  logic wave_pin, prd_flag, irq;
  logic [1:0] cmp_flag;
  logic [15:0] count;

  int checks = 0, errors = 0, cyc = 0;
  bit ext_run = 0;
  bit mon_on = 0;

  typedef struct { int width; int period; string req; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  pwmt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .tick_sel(tick_sel),
    .pwm_en(pwm_en), .oneshot_en(oneshot_en), .pin_en(pin_en),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .prd_ie(prd_ie), .cmp_ie(cmp_ie),
    .irq_mask(irq_mask), .wr_en(wr_en), .wr_ch(wr_ch), .wr_hi(wr_hi),
    .wr_data(wr_data), .prd_clr(prd_clr), .cmp_clr(cmp_clr),
    .wave_pin(wave_pin), .prd_flag(prd_flag), .cmp_flag(cmp_flag),
    .irq(irq), .count(count)
  );

  initial forever begin
    if (ext_run) begin
      repeat (5) @(posedge clk);
      #1 ext_tick = ~ext_tick;
    end else @(posedge clk);
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
    end
  endtask

  // Monitor: measures pulse width and period, pops expectations
  bit seen_rise = 0, have_w = 0, pin_prev = 0;
  int t_rise = 0, w_meas = 0, p_meas = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (!seen_rise) begin
        if (wave_pin && !pin_prev) begin seen_rise = 1; t_rise = cyc; have_w = 0; end
      end else begin
        if (!wave_pin && pin_prev) begin w_meas = cyc - t_rise; have_w = 1; end
        if (wave_pin && !pin_prev) begin
          p_meas = cyc - t_rise;
          if (have_w && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(w_meas == e.width, {e.req, " width"}, w_meas, e.width);
            check(p_meas == e.period, {e.req, " period"}, p_meas, e.period);
          end
          t_rise = cyc; have_w = 0;
        end
      end
    end else seen_rise = 0;
    pin_prev = wave_pin;
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_cmp(bit ch, logic [15:0] v);
    wr_en = 1; wr_ch = ch; wr_hi = 1; wr_data = v[15:8];
    @(negedge clk);
    wr_hi = 0; wr_data = v[7:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  // Driver: configure, push expected items, wait for the monitor to drain
  task automatic run_pwm(logic [1:0] sel, int div, int c1, int c2, bit shot, string req);
    pwm_en = 1; oneshot_en = shot; tick_sel = sel; lvl_a = 1; lvl_b = 0; pin_en = 1;
    ext_run = (sel == 2'b11);
    do_reset();
    wr_cmp(1, 16'(c2));
    wr_cmp(0, 16'(c1));
    repeat ((c2 + 5) * div * 2) @(negedge clk);
    for (int i = 0; i < 3; i++) exp_q.push_back('{(c2 - c1) * div, (c2 + 5) * div, req});
    mon_on = 1;
    while (exp_q.size() != 0) @(negedge clk);
    mon_on = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(count == 16'hFFFC, "R1 count", count, 16'hFFFC);
    check(wave_pin == 0, "R1 pin", wave_pin, 0);
    check(prd_flag == 0 && cmp_flag == 0 && irq == 0, "R1 flags", {prd_flag, cmp_flag, irq}, 0);

    // R2 R3 R4 R8: divide-by-2, 4, 8 and external ticks
    run_pwm(2'b01, 2, 3, 9, 0, "R3 R4 div2");
    run_pwm(2'b00, 4, 2, 5, 0, "R2 div4");
    run_pwm(2'b10, 8, 1, 4, 0, "R2 div8");
    run_pwm(2'b11, 10, 2, 6, 0, "R2 ext");
    ext_run = 0;
    // R9 both modes selected
    run_pwm(2'b01, 2, 3, 9, 1, "R9 pwm+oneshot");
    oneshot_en = 0;
    check(cmp_flag == 2'b00, "R7 no cmp flags in PWM", cmp_flag, 0);

    // R5 set/clear collision, R6 irq gating
    prd_ie = 1; irq_mask = 0;
    prd_clr = 1;
    begin
      int ones = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (prd_flag) ones++; end
      check(ones >= 3 && ones <= 4, "R5 set wins over clear", ones, 3);
    end
    prd_clr = 0;
    repeat (30) @(negedge clk);
    check(prd_flag == 1, "R5 flag sticks", prd_flag, 1);
    check(irq == 1, "R6 irq enabled", irq, 1);
    irq_mask = 1; #1;
    check(irq == 0, "R6 irq masked", irq, 0);
    irq_mask = 0; prd_ie = 0; #1;
    check(irq == 0, "R6 irq disabled", irq, 0);

    // R8 high byte alone disables channel 2
    wr_en = 1; wr_ch = 1; wr_hi = 1; wr_data = 8'h00;
    @(negedge clk); wr_en = 0;
    prd_clr = 1; @(negedge clk); @(negedge clk); prd_clr = 0;
    repeat (60) @(negedge clk);
    check(prd_flag == 0, "R8 no period event while disabled", prd_flag, 0);
    check(count > 16'h0009 && count < 16'h0100, "R8 counter passes C2", count, 16'h0010);

    // R4 equal levels, R10 pin enable
    lvl_b = 1; lvl_a = 1;
    do_reset(); wr_cmp(1, 16'd9); wr_cmp(0, 16'd3);
    repeat (40) @(negedge clk);
    begin
      int lows = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (!wave_pin) lows++; end
      check(lows == 0, "R4 equal levels constant", lows, 0);
    end
    pin_en = 0; #1;
    check(wave_pin == 0, "R10 pin disabled", wave_pin, 0);
    pin_en = 1;

    // R11 normal mode
    pwm_en = 0; oneshot_en = 0; lvl_a = 1; cmp_ie = 1;
    do_reset(); wr_cmp(0, 16'd3); wr_cmp(1, 16'd5);
    repeat (40) @(negedge clk);
    check(cmp_flag == 2'b11, "R11 both compare flags", cmp_flag, 3);
    check(wave_pin == 1, "R11 pin at lvl_a", wave_pin, 1);
    check(count > 16'd5 && count < 16'h0100, "R11 free run past C2", count, 16'h0010);
    check(prd_flag == 0, "R11 no period flag", prd_flag, 0);
    check(irq == 1, "R6 cmp irq", irq, 1);
    cmp_clr = 2'b11; @(negedge clk); cmp_clr = 0;
    check(cmp_flag == 2'b00, "R11 flags cleared", cmp_flag, 0);
    check(irq == 0, "R6 irq drops", irq, 0);
    cmp_ie = 0;

    // R12 one-shot halt
    oneshot_en = 1;
    do_reset(); wr_cmp(0, 16'd4);
    repeat (60) @(negedge clk);
    check(count == 16'd4, "R12 halted at C1", count, 4);
    check(wave_pin == 1, "R12 pin at lvl_a", wave_pin, 1);
    repeat (20) @(negedge clk);
    check(count == 16'd4, "R12 still halted", count, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule